// File: doc/BRIEF.md
# Sectored Write-Through Data Cache

This block is a set-associative read/write data cache whose lines are 128 bytes long but whose contents are tracked in four 32-byte sectors. A single tag per way identifies which aligned 128-byte region of memory the way holds. Each sector of that way has its own valid flag. A read arrives as a line address with a mask that names the sectors it wants. The cache answers with a per-sector hit mask and the line data. It fetches from the next level only those requested sectors that are absent. Every fetch moves exactly one sector, and neighbouring sectors or lines are never fetched ahead of time.

Stores are write-through. Each store names one sector and carries 32 bytes of data with a byte-enable mask. The store is forwarded downstream one cycle later. If the addressed sector is already present, the enabled bytes are merged into the cached copy as well. A store that misses does not allocate a line. Only one miss is handled at a time. While sectors are being fetched the cache raises `stall`, and any request presented during that time is dropped.

Top module: `sectored_wt_cache`

## Requirements
- R1: A read whose line tag matches and whose requested sectors are all valid raises `rsp_valid` in the next cycle, with `rsp_hit_mask` equal to `req_mask`, no downstream read and `stall` low.
- R2: A read whose line tag matches no way fetches exactly the requested sectors, lowest sector index first, one `dn_rd_valid` pulse per sector. Each pulse has `dn_rd_addr` = {line, 2-bit sector index}, and `rsp_hit_mask` is zero.
- R3: A read whose tag matches while some requested sectors are invalid fetches only those invalid requested sectors. Its `rsp_hit_mask` lists the requested sectors that were already valid.
- R4: A sector that has been fetched becomes valid, so a later read of it under the same tag hits without a downstream read.
- R5: Putting a new tag into a way clears all four sector valid flags of that way before any fill, so sectors left behind by the evicted line never hit.
- R6: `stall` is high from the cycle after a read that needs a fetch until the cycle of its response. Only one fetch is outstanding at a time, and requests presented while `stall` is high are ignored.
- R7: Every accepted store drives `dn_wr_valid` in the next cycle with `dn_wr_addr` = {line, sector}, the store data and its 32-bit byte enable (bit b covers byte b, bits 8b+7..8b).
- R8: A store to a valid sector of a resident line updates the enabled bytes of the cached copy, and a later read returns the merged data.
- R9: A store whose line is not resident allocates nothing, so a later read of that line misses.
- R10: A store to a resident line whose addressed sector is invalid leaves that sector invalid.
- R11: A read miss places the line in the lowest-numbered way that holds no line. When every way is in use, a 3-bit tree pseudo-LRU per set picks the way. Every read that hits or allocates, and every store whose tag hits, marks its way as most recent: the root bit then points to the other pair of ways, and that pair's bit points to the other way of the pair. After reset all bits are zero, which points to way 0.
- R12: After reset, `stall`, `rsp_valid`, `dn_rd_valid` and `dn_wr_valid` are low and no line is resident.
- R13: In `rsp_data` the sector s occupies bits 256s+255..256s. For every requested sector it equals the current downstream content, including bytes written through earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = read |
| req_line | input | 25 | Line address (byte address / 128); low 6 bits select the set |
| req_mask | input | 4 | Read: sectors requested |
| req_wsect | input | 2 | Store: sector index within the line |
| req_wdata | input | 256 | Store data |
| req_wbe | input | 32 | Store byte enables |
| stall | output | 1 | Miss in progress, requests ignored |
| rsp_valid | output | 1 | Read response valid |
| rsp_hit_mask | output | 4 | Requested sectors that were present on arrival |
| rsp_data | output | 1024 | Line data, sector s at bits 256s+255..256s |
| dn_rd_valid | output | 1 | Downstream sector fetch request (one-cycle pulse) |
| dn_rd_addr | output | 27 | Sector address of the fetch |
| dn_fill_valid | input | 1 | Fetched sector data present |
| dn_fill_data | input | 256 | Fetched sector data |
| dn_wr_valid | output | 1 | Downstream store |
| dn_wr_addr | output | 27 | Sector address of the store |
| dn_wr_data | output | 256 | Store data |
| dn_wr_be | output | 32 | Store byte enables |

## Verification
The properties take for granted that the next level returns exactly one `dn_fill_valid` pulse for each `dn_rd_valid` pulse, always after it and never without one pending, and that it accepts every store as it is issued. The bench's downstream model answers each fetch after a fixed two-cycle delay and takes stores unconditionally, so it stays inside those limits. Requests are still driven while `stall` is high, so the dropping of such requests is exercised rather than assumed.

// File: rtl/sc_pkg.sv
package sc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2
   } sc_state_e;

   localparam int unsigned SC_BYTE_BITS = 8;

endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
   parameter int unsigned SETS    = 64,
   parameter int unsigned WAYS    = 4,
   parameter int unsigned TAG_W   = 19,
   parameter int unsigned SECTORS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [$clog2(SETS)-1:0]     lk_set,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic                        hit_any,
   output logic [$clog2(WAYS)-1:0]     hit_way,
   output logic [SECTORS-1:0]          hit_sv,
   output logic                        free_any,
   output logic [$clog2(WAYS)-1:0]     free_way,
   input  logic                        al_en,
   input  logic [$clog2(SETS)-1:0]     al_set,
   input  logic [$clog2(WAYS)-1:0]     al_way,
   input  logic [TAG_W-1:0]            al_tag,
   input  logic                        sv_en,
   input  logic [$clog2(SETS)-1:0]     sv_set,
   input  logic [$clog2(WAYS)-1:0]     sv_way,
   input  logic [$clog2(SECTORS)-1:0]  sv_idx
);
   localparam int unsigned WAY_W = $clog2(WAYS);

   logic [TAG_W-1:0]   tag_q [SETS][WAYS];
   logic [WAYS-1:0]    lv_q  [SETS];
   logic [SECTORS-1:0] sv_q  [SETS][WAYS];
   logic [WAYS-1:0]    match;

   // tags need no reset: the line-valid flags gate them
   always_ff @(posedge clk) begin
      if (al_en) tag_q[al_set][al_way] <= al_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            lv_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) sv_q[s][w] <= '0;
         end
      end else begin
         if (al_en) begin
            lv_q[al_set][al_way] <= 1'b1;
            sv_q[al_set][al_way] <= '0;
         end
         if (sv_en) sv_q[sv_set][sv_way][sv_idx] <= 1'b1;
      end
   end

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign match[w] = lv_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      end
   endgenerate

   always_comb begin
      hit_any  = 1'b0;
      hit_way  = '0;
      free_any = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) begin
            hit_any = 1'b1;
            hit_way = WAY_W'(w);
         end
         if (!lv_q[lk_set][w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
      hit_sv = hit_any ? sv_q[lk_set][hit_way] : '0;
   end

endmodule

// File: rtl/sc_plru.sv
module sc_plru #(
   parameter int unsigned SETS = 64,
   parameter int unsigned WAYS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    touch_en,
   input  logic [$clog2(SETS)-1:0] touch_set,
   input  logic [$clog2(WAYS)-1:0] touch_way,
   input  logic [$clog2(SETS)-1:0] look_set,
   output logic [$clog2(WAYS)-1:0] victim
);
   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned LVL   = WAY_W;

   // heap-ordered tree: node 1 is the root, node n has children 2n and 2n+1
   logic [WAYS-1:0] bits_q [SETS];
   logic [WAYS-1:0] nxt;
   logic [WAYS-1:0] cur;

   always_comb begin
      int node;
      nxt  = bits_q[touch_set];
      node = int'(touch_way) + WAYS;
      for (int l = 0; l < LVL; l++) begin
         nxt[node >> 1] = ~node[0];
         node = node >> 1;
      end
   end

   always_comb begin
      int node;
      cur  = bits_q[look_set];
      node = 1;
      for (int l = 0; l < LVL; l++) begin
         node = 2 * node + int'(cur[node]);
      end
      victim = WAY_W'(node - WAYS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
      end else if (touch_en) begin
         bits_q[touch_set] <= nxt;
      end
   end

endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
   parameter int unsigned SETS        = 64,
   parameter int unsigned WAYS        = 4,
   parameter int unsigned SECTORS     = 4,
   parameter int unsigned SECTOR_BITS = 256
) (
   input  logic                           clk,
   input  logic                           we,
   input  logic [$clog2(SETS)-1:0]        w_set,
   input  logic [$clog2(WAYS)-1:0]        w_way,
   input  logic [$clog2(SECTORS)-1:0]     w_sect,
   input  logic [SECTOR_BITS-1:0]         w_data,
   input  logic [SECTOR_BITS/8-1:0]       w_be,
   input  logic [$clog2(SETS)-1:0]        r_set,
   input  logic [$clog2(WAYS)-1:0]        r_way,
   output logic [SECTORS*SECTOR_BITS-1:0] r_line
);
   import sc_pkg::*;
   localparam int unsigned BE_W    = SECTOR_BITS / SC_BYTE_BITS;
   localparam int unsigned ENTRIES = SETS * WAYS * SECTORS;

   logic [SECTOR_BITS-1:0] mem_q [ENTRIES];
   int                     w_idx;
   int                     r_base;

   assign w_idx  = (int'(w_set) * WAYS + int'(w_way)) * SECTORS + int'(w_sect);
   assign r_base = (int'(r_set) * WAYS + int'(r_way)) * SECTORS;

   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < BE_W; b++) begin
            if (w_be[b]) mem_q[w_idx][b*SC_BYTE_BITS +: SC_BYTE_BITS] <= w_data[b*SC_BYTE_BITS +: SC_BYTE_BITS];
         end
      end
   end

   generate
      for (genvar s = 0; s < SECTORS; s++) begin : g_rd
         assign r_line[s*SECTOR_BITS +: SECTOR_BITS] = mem_q[r_base + s];
      end
   endgenerate

endmodule

// File: rtl/sectored_wt_cache.sv
module sectored_wt_cache #(
   parameter int unsigned LINE_W      = 25,
   parameter int unsigned SETS        = 64,
   parameter int unsigned WAYS        = 4,
   parameter int unsigned SECTORS     = 4,
   parameter int unsigned SECTOR_BITS = 256
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         req_valid,
   input  logic                                         req_write,
   input  logic [LINE_W-1:0]                            req_line,
   input  logic [SECTORS-1:0]                           req_mask,
   input  logic [$clog2(SECTORS)-1:0]                   req_wsect,
   input  logic [SECTOR_BITS-1:0]                       req_wdata,
   input  logic [SECTOR_BITS/8-1:0]                     req_wbe,
   output logic                                         stall,
   output logic                                         rsp_valid,
   output logic [SECTORS-1:0]                           rsp_hit_mask,
   output logic [SECTORS*SECTOR_BITS-1:0]               rsp_data,
   output logic                                         dn_rd_valid,
   output logic [LINE_W+$clog2(SECTORS)-1:0]            dn_rd_addr,
   input  logic                                         dn_fill_valid,
   input  logic [SECTOR_BITS-1:0]                       dn_fill_data,
   output logic                                         dn_wr_valid,
   output logic [LINE_W+$clog2(SECTORS)-1:0]            dn_wr_addr,
   output logic [SECTOR_BITS-1:0]                       dn_wr_data,
   output logic [SECTOR_BITS/8-1:0]                     dn_wr_be
);
   import sc_pkg::*;

   localparam int unsigned SET_W  = $clog2(SETS);
   localparam int unsigned WAY_W  = $clog2(WAYS);
   localparam int unsigned SIDX_W = $clog2(SECTORS);
   localparam int unsigned TAG_W  = LINE_W - SET_W;
   localparam int unsigned BE_W   = SECTOR_BITS / SC_BYTE_BITS;

   generate
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("WAYS must be a power of two, at least 2");
      end
      if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
         $error("SETS must be a power of two, at least 2");
      end
      if (SECTORS < 2 || (1 << SIDX_W) != SECTORS) begin : g_bad_sect
         $error("SECTORS must be a power of two, at least 2");
      end
      if (SECTOR_BITS % SC_BYTE_BITS != 0) begin : g_bad_sbits
         $error("SECTOR_BITS must be a whole number of bytes");
      end
      if (LINE_W <= SET_W) begin : g_bad_line
         $error("LINE_W must leave at least one tag bit");
      end
   endgenerate

   sc_state_e           state_q;
   logic [SET_W-1:0]    set_i;
   logic [TAG_W-1:0]    tag_i;
   logic                hit_any, free_any;
   logic [WAY_W-1:0]    hit_way, free_way, plru_way, pick_way;
   logic [SECTORS-1:0]  hit_sv, missing;
   logic                accept, rd_acc, wr_acc, alloc, wr_hit, fill_done, touch_en;

   logic [SET_W-1:0]    cur_set_q;
   logic [WAY_W-1:0]    cur_way_q;
   logic [LINE_W-1:0]   cur_line_q;
   logic [SECTORS-1:0]  pend_q, hitm_q, fetch_bit;
   logic [SIDX_W-1:0]   fetch_idx;
   logic                rsp_q;

   logic                ds_we;
   logic [SET_W-1:0]    ds_set;
   logic [WAY_W-1:0]    ds_way;
   logic [SIDX_W-1:0]   ds_sect;
   logic [SECTOR_BITS-1:0] ds_data;
   logic [BE_W-1:0]     ds_be;

   assign set_i = req_line[SET_W-1:0];
   assign tag_i = req_line[LINE_W-1:SET_W];

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign rd_acc    = accept && !req_write;
   assign wr_acc    = accept && req_write;
   assign missing   = req_mask & ~hit_sv;
   assign alloc     = rd_acc && !hit_any && (missing != '0);
   assign pick_way  = hit_any ? hit_way : (free_any ? free_way : plru_way);
   assign wr_hit    = wr_acc && hit_any && hit_sv[req_wsect];
   assign fill_done = (state_q == ST_WAIT) && dn_fill_valid;
   assign touch_en  = (rd_acc && (hit_any || alloc)) || (wr_acc && hit_any);

   // lowest pending sector is fetched first
   always_comb begin
      fetch_idx = '0;
      for (int s = SECTORS - 1; s >= 0; s--) begin
         if (pend_q[s]) fetch_idx = SIDX_W'(s);
      end
      fetch_bit = SECTORS'(1) << fetch_idx;
   end

   sc_tag_store #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SECTORS(SECTORS)
   ) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_set(set_i), .lk_tag(tag_i),
      .hit_any(hit_any), .hit_way(hit_way), .hit_sv(hit_sv),
      .free_any(free_any), .free_way(free_way),
      .al_en(alloc), .al_set(set_i), .al_way(pick_way), .al_tag(tag_i),
      .sv_en(fill_done), .sv_set(cur_set_q), .sv_way(cur_way_q), .sv_idx(fetch_idx)
   );

   sc_plru #(
      .SETS(SETS), .WAYS(WAYS)
   ) u_repl (
      .clk(clk), .rst_n(rst_n),
      .touch_en(touch_en), .touch_set(set_i), .touch_way(pick_way),
      .look_set(set_i), .victim(plru_way)
   );

   assign ds_we   = fill_done || wr_hit;
   assign ds_set  = fill_done ? cur_set_q : set_i;
   assign ds_way  = fill_done ? cur_way_q : hit_way;
   assign ds_sect = fill_done ? fetch_idx : req_wsect;
   assign ds_data = fill_done ? dn_fill_data : req_wdata;
   assign ds_be   = fill_done ? {BE_W{1'b1}} : req_wbe;

   sc_data_store #(
      .SETS(SETS), .WAYS(WAYS), .SECTORS(SECTORS), .SECTOR_BITS(SECTOR_BITS)
   ) u_data (
      .clk(clk), .we(ds_we),
      .w_set(ds_set), .w_way(ds_way), .w_sect(ds_sect),
      .w_data(ds_data), .w_be(ds_be),
      .r_set(cur_set_q), .r_way(cur_way_q), .r_line(rsp_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cur_set_q  <= '0;
         cur_way_q  <= '0;
         cur_line_q <= '0;
         pend_q     <= '0;
         hitm_q     <= '0;
         rsp_q      <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (rd_acc) begin
                  cur_set_q  <= set_i;
                  cur_way_q  <= pick_way;
                  cur_line_q <= req_line;
                  hitm_q     <= req_mask & ~missing;
                  pend_q     <= missing;
                  if (missing == '0) rsp_q   <= 1'b1;
                  else               state_q <= ST_FETCH;
               end
            end
            ST_FETCH: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (dn_fill_valid) begin
                  pend_q <= pend_q & ~fetch_bit;
                  if ((pend_q & ~fetch_bit) == '0) begin
                     state_q <= ST_IDLE;
                     rsp_q   <= 1'b1;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn_wr_valid <= 1'b0;
         dn_wr_addr  <= '0;
         dn_wr_data  <= '0;
         dn_wr_be    <= '0;
      end else begin
         dn_wr_valid <= wr_acc;
         if (wr_acc) begin
            dn_wr_addr <= {req_line, req_wsect};
            dn_wr_data <= req_wdata;
            dn_wr_be   <= req_wbe;
         end
      end
   end

   assign stall        = (state_q != ST_IDLE);
   assign rsp_valid    = rsp_q;
   assign rsp_hit_mask = hitm_q;
   assign dn_rd_valid  = (state_q == ST_FETCH);
   assign dn_rd_addr   = {cur_line_q, fetch_idx};

endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
   parameter int unsigned LINE_W  = 25,
   parameter int unsigned SECTORS = 4
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               req_valid,
   input logic                               req_write,
   input logic [LINE_W-1:0]                  req_line,
   input logic [SECTORS-1:0]                 req_mask,
   input logic [$clog2(SECTORS)-1:0]         req_wsect,
   input logic                               stall,
   input logic                               rsp_valid,
   input logic [SECTORS-1:0]                 rsp_hit_mask,
   input logic                               dn_rd_valid,
   input logic [LINE_W+$clog2(SECTORS)-1:0]  dn_rd_addr,
   input logic                               dn_wr_valid,
   input logic [LINE_W+$clog2(SECTORS)-1:0]  dn_wr_addr
);
   localparam int unsigned SIDX_W = $clog2(SECTORS);

   logic [SECTORS-1:0] last_mask;
   logic [LINE_W-1:0]  last_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_mask <= '0;
         last_line <= '0;
      end else if (req_valid && !req_write && !stall) begin
         last_mask <= req_mask;
         last_line <= req_line;
      end
   end

   // R6: a fetch is only issued while the cache is stalled
   a_r6_fetch_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      dn_rd_valid |-> stall);

   // R6: one fetch at a time, never two in consecutive cycles
   a_r6_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      dn_rd_valid |=> !dn_rd_valid);

   // R6: a request presented while stalled produces no store
   a_r6_drop_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && stall) |=> !dn_wr_valid);

   // R1: a response never coincides with a stall
   a_r1_rsp_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !stall);

   // R7: accepted store forwarded next cycle to its sector address
   a_r7_store_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !stall) |=> (dn_wr_valid && dn_wr_addr == $past({req_line, req_wsect})));

   // R3: hit mask reports only sectors that were asked for
   a_r3_hit_subset: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_hit_mask & ~last_mask) == '0));

   // R2: every fetch targets a requested sector of the missing line
   a_r2_fetch_requested: assert property (@(posedge clk) disable iff (!rst_n)
      dn_rd_valid |-> (last_mask[dn_rd_addr[SIDX_W-1:0]] && dn_rd_addr[LINE_W+SIDX_W-1:SIDX_W] == last_line));

   // R12: outputs quiet while reset is applied
   always @(posedge clk) begin
      if (!rst_n && $past(!rst_n)) begin
         a_r12_reset_quiet: assert (!stall && !rsp_valid && !dn_rd_valid && !dn_wr_valid);
      end
   end

endmodule

bind sectored_wt_cache sc_checker #(
   .LINE_W(LINE_W), .SECTORS(SECTORS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
   .req_mask(req_mask), .req_wsect(req_wsect),
   .stall(stall), .rsp_valid(rsp_valid), .rsp_hit_mask(rsp_hit_mask),
   .dn_rd_valid(dn_rd_valid), .dn_rd_addr(dn_rd_addr),
   .dn_wr_valid(dn_wr_valid), .dn_wr_addr(dn_wr_addr)
);

// File: tb/sim_sectored_wt_cache.sv
`timescale 1ns/1ps
module sim_sectored_wt_cache;
   localparam int LW = 25;
   localparam int NSETS = 64;
   localparam int NWAYS = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [LW-1:0] req_line = '0;
   logic [3:0]    req_mask = '0;
   logic [1:0]    req_wsect = '0;
   logic [255:0]  req_wdata = '0;
   logic [31:0]   req_wbe = '0;
   logic          stall, rsp_valid, dn_rd_valid, dn_wr_valid;
   logic [3:0]    rsp_hit_mask;
   logic [1023:0] rsp_data;
   logic [26:0]   dn_rd_addr, dn_wr_addr;
   logic          dn_fill_valid = 1'b0;
   logic [255:0]  dn_fill_data = '0;
   logic [255:0]  dn_wr_data;
   logic [31:0]   dn_wr_be;

   sectored_wt_cache u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_line(req_line), .req_mask(req_mask), .req_wsect(req_wsect),
      .req_wdata(req_wdata), .req_wbe(req_wbe), .stall(stall),
      .rsp_valid(rsp_valid), .rsp_hit_mask(rsp_hit_mask), .rsp_data(rsp_data),
      .dn_rd_valid(dn_rd_valid), .dn_rd_addr(dn_rd_addr),
      .dn_fill_valid(dn_fill_valid), .dn_fill_data(dn_fill_data),
      .dn_wr_valid(dn_wr_valid), .dn_wr_addr(dn_wr_addr),
      .dn_wr_data(dn_wr_data), .dn_wr_be(dn_wr_be));

   int total = 0, bad = 0;
   bit done = 0;

   // reference: downstream memory plus which sectors the cache holds
   logic [255:0] mem [int];
   logic [18:0]  m_tag [NSETS][NWAYS];
   bit           m_lv  [NSETS][NWAYS];
   logic [3:0]   m_sv  [NSETS][NWAYS];
   logic [3:0]   m_pl  [NSETS];
   int           exp_rd [$];

   function automatic logic [255:0] mem_rd(int a);
      logic [255:0] v;
      if (mem.exists(a)) return mem[a];
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = a * 32'h9E3779B1 + k * 32'h01010101 + 32'h5A5A0000;
      return v;
   endfunction

   task automatic chk(input bit ok, input string r, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
      end
   endtask

   function automatic void touch(int s, int w);
      if (w < 2) begin m_pl[s][1] = 1'b1; m_pl[s][2] = (w == 0); end
      else       begin m_pl[s][1] = 1'b0; m_pl[s][3] = (w == 2); end
   endfunction

   function automatic int victim(int s);
      for (int w = 0; w < NWAYS; w++) if (!m_lv[s][w]) return w;
      if (!m_pl[s][1]) return m_pl[s][2] ? 1 : 0;
      return m_pl[s][3] ? 3 : 2;
   endfunction

   function automatic int find(int s, logic [18:0] t);
      for (int w = 0; w < NWAYS; w++) if (m_lv[s][w] && m_tag[s][w] == t) return w;
      return -1;
   endfunction

   // downstream model: fetch answered two cycles later, checked each clock
   int fcnt = 0;
   int faddr = 0;
   always @(negedge clk) begin
      dn_fill_valid = 1'b0;
      if (fcnt > 0) begin
         fcnt--;
         if (fcnt == 0) begin
            dn_fill_valid = 1'b1;
            dn_fill_data  = mem_rd(faddr);
         end
      end
      if (rst_n && dn_rd_valid) begin
         if (exp_rd.size() == 0) chk(0, "R2", "unexpected fetch", 256'(dn_rd_addr), 0);
         else begin
            int e;
            e = exp_rd.pop_front();
            chk(int'(dn_rd_addr) == e, "R2", "fetch address", 256'(dn_rd_addr), 256'(e));
         end
         faddr = int'(dn_rd_addr);
         fcnt  = 2;
      end
   end

   task automatic do_read(input logic [LW-1:0] line, input logic [3:0] mask,
                          input string r, input bit poke = 0);
      int s, w, cnt;
      logic [18:0] t;
      logic [3:0] hm, miss;
      s = int'(line[5:0]);
      t = line[24:6];
      w = find(s, t);
      if (w >= 0) begin
         hm   = mask & m_sv[s][w];
         miss = mask & ~m_sv[s][w];
         touch(s, w);
      end else begin
         hm   = 4'b0;
         miss = mask;
         if (miss != 0) begin
            w = victim(s);
            m_tag[s][w] = t; m_lv[s][w] = 1'b1; m_sv[s][w] = 4'b0;
            touch(s, w);
         end
      end
      for (int k = 0; k < 4; k++) if (miss[k]) exp_rd.push_back((int'(line) << 2) | k);
      if (w >= 0) m_sv[s][w] = m_sv[s][w] | miss;
      req_valid = 1; req_write = 0; req_line = line; req_mask = mask;
      @(negedge clk);
      req_valid = 0;
      if (miss == 0) begin
         chk(rsp_valid && !stall, "R1", "hit answered next cycle", {rsp_valid, stall}, 2'b10);
      end else begin
         chk(stall, "R6", "stall after miss", stall, 1);
         if (poke) begin
            req_valid = 1; req_write = 1; req_line = line ^ 25'h40; req_wsect = 0;
            req_wdata = '1; req_wbe = '1;
            @(negedge clk);
            req_valid = 0;
            chk(!dn_wr_valid, "R6", "store during stall dropped", dn_wr_valid, 0);
         end
      end
      cnt = 0;
      while (!rsp_valid && cnt < 60) begin @(negedge clk); cnt++; end
      chk(rsp_valid, r, "response arrived", rsp_valid, 1);
      chk(rsp_hit_mask == hm, r, "hit mask", rsp_hit_mask, hm);
      for (int k = 0; k < 4; k++)
         if (mask[k]) chk(rsp_data[k*256 +: 256] == mem_rd((int'(line) << 2) | k), "R13", "sector data",
                          rsp_data[k*256 +: 256], mem_rd((int'(line) << 2) | k));
      chk(exp_rd.size() == 0, r, "all expected fetches issued", exp_rd.size(), 0);
      exp_rd.delete();
   endtask

   task automatic do_write(input logic [LW-1:0] line, input logic [1:0] sect,
                           input logic [255:0] data, input logic [31:0] be, input string r);
      int s, w, a;
      logic [255:0] cur;
      s = int'(line[5:0]);
      w = find(s, line[24:6]);
      if (w >= 0) touch(s, w);
      a = (int'(line) << 2) | int'(sect);
      cur = mem_rd(a);
      for (int b = 0; b < 32; b++) if (be[b]) cur[b*8 +: 8] = data[b*8 +: 8];
      mem[a] = cur;
      req_valid = 1; req_write = 1; req_line = line; req_wsect = sect;
      req_wdata = data; req_wbe = be;
      @(negedge clk);
      req_valid = 0; req_write = 0;
      chk(dn_wr_valid, "R7", "store forwarded", dn_wr_valid, 1);
      chk(dn_wr_addr == 27'(a), "R7", "store address", dn_wr_addr, 256'(a));
      chk(dn_wr_data == data, "R7", "store data", dn_wr_data, data);
      chk(dn_wr_be == be, "R7", "store byte enable", dn_wr_be, be);
      chk(!stall, r, "store does not stall", stall, 0);
   endtask

   task automatic finish_run;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      for (int s = 0; s < NSETS; s++) begin
         m_pl[s] = 4'b0;
         for (int w = 0; w < NWAYS; w++) begin m_lv[s][w] = 0; m_sv[s][w] = 0; m_tag[s][w] = 0; end
      end
      repeat (4) @(negedge clk);
      chk(!stall && !rsp_valid && !dn_rd_valid && !dn_wr_valid, "R12", "quiet in reset",
          {stall, rsp_valid, dn_rd_valid, dn_wr_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!stall && !rsp_valid && !dn_rd_valid && !dn_wr_valid, "R12", "quiet after reset",
          {stall, rsp_valid, dn_rd_valid, dn_wr_valid}, 0);

      // R2 full miss with sparse mask; R6 poke while stalled
      do_read(25'h0000A3, 4'b0101, "R2", 1);
      // R3 partial miss
      do_read(25'h0000A3, 4'b0111, "R3");
      // R1 / R4 all present
      do_read(25'h0000A3, 4'b0111, "R4");
      // R8 merge into a valid sector
      do_write(25'h0000A3, 2'd1, {8{32'hC0DE_1234}}, 32'h0000_FFFF, "R8");
      do_read(25'h0000A3, 4'b0010, "R8");
      // R10 store to invalid sector of resident line
      do_write(25'h0000A3, 2'd3, {8{32'hFEED_0001}}, 32'hF0F0_F0F0, "R10");
      do_read(25'h0000A3, 4'b1000, "R10");
      // R9 store miss allocates nothing
      do_write(25'h000127, 2'd0, {8{32'h1111_2222}}, 32'hFFFF_FFFF, "R9");
      do_read(25'h000127, 4'b0001, "R9");

      // R11 / R5 replacement in set 5
      for (int k = 1; k <= 4; k++) do_read(25'((k << 6) | 5), 4'b1111, "R11");
      do_read(25'((2 << 6) | 5), 4'b0001, "R11");
      do_read(25'((1 << 6) | 5), 4'b0001, "R11");
      do_write(25'((3 << 6) | 5), 2'd2, {8{32'hABCD_EF01}}, 32'h0F0F_0F0F, "R11");
      do_read(25'((5 << 6) | 5), 4'b0001, "R11");
      do_read(25'((5 << 6) | 5), 4'b1111, "R5");
      for (int k = 1; k <= 5; k++) do_read(25'((k << 6) | 5), 4'b0011, "R11");

      // mixed traffic over a small pool of lines
      for (int i = 0; i < 300; i++) begin
         logic [LW-1:0] ln;
         ln = 25'(($urandom_range(0, 5) << 6) | $urandom_range(8, 10));
         if ($urandom_range(0, 9) < 6)
            do_read(ln, 4'($urandom_range(1, 15)), "R4");
         else
            do_write(ln, 2'($urandom_range(0, 3)), {8{$urandom}}, $urandom, "R8");
      end

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule